// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control unit for a 32-bit processor datapath that time-shares a single ALU and a single memory across several clock cycles per instruction. It watches the 6-bit opcode held in the instruction register. It steps through a fixed schedule of cycles for each instruction class and drives the write enables, memory strobes, multiplexer selects and ALU operation class that the datapath needs in each cycle.

Every instruction starts with a fetch cycle and a decode cycle. The decode cycle computes the branch target before the opcode is known, so a branch needs only one more cycle. Loads take five cycles, stores and register-to-register arithmetic take four, and branch-equal and jump take three. An unknown opcode is dropped after decode with no side effects.

The controller is a Moore machine: every output is a function of the current state only. The only data input is the opcode, which is level-sampled and has no handshake. The state register can be built binary or one-hot through a parameter, and the choice does not change the behaviour.

Top module: `mcyc_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the outputs show the fetch pattern of R2. Reset may be asserted in any cycle and takes effect at once.
- R2: In a fetch cycle, `ir_we`, `pc_we` and `mem_rd` are 1. The address select `addr_sel` is 0 (PC), `alu_a_sel` is 0 (PC), `alu_b_sel` is 01 (constant 4), `alu_op` is 00 (add) and `pc_src` is 00 (ALU result). The opcode present during fetch has no effect, and the next cycle is always decode.
- R3: In a decode cycle, `alu_a_sel` is 0 (PC), `alu_b_sel` is 11 (sign-extended offset shifted left by 2) and `alu_op` is 00. No write enable and no memory strobe is asserted.
- R4: After the instruction's last cycle the next cycle is fetch. The total cycle counts are 4 for opcode 000000 (R-type), 5 for 100011 (load), 4 for 101011 (store), 3 for 000100 (branch-equal) and 3 for 000010 (jump).
- R5: For load and store, cycle 3 drives `alu_a_sel`=1 (register A), `alu_b_sel`=10 (sign-extended offset) and `alu_op`=00, with no write enable or strobe.
- R6: A load drives `mem_rd`=1 with `addr_sel`=1 (ALUOut) in cycle 4. In cycle 5 it drives `rf_we`=1 with `rf_dst_sel`=0 (destination from bits 20:16) and `rf_wsrc_mem`=1 (data from MDR).
- R7: A store drives `mem_wr`=1 with `addr_sel`=1 in cycle 4 and does not assert `rf_we`.
- R8: An R-type instruction drives `alu_a_sel`=1, `alu_b_sel`=00 (register B) and `alu_op`=10 (set by function field) in cycle 3. In cycle 4 it drives `rf_we`=1 with `rf_dst_sel`=1 (bits 15:11) and `rf_wsrc_mem`=0 (ALUOut).
- R9: Branch-equal drives `pc_we_cond`=1, `pc_src`=01 (ALUOut), `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=01 (subtract, for the equality test) in cycle 3, with `pc_we`=0.
- R10: Jump drives `pc_we`=1 with `pc_src`=10 (upper 4 PC bits joined to the 26-bit target shifted left by 2) in cycle 3.
- R11: Any other opcode ends after decode and the next cycle is fetch. No write enable or strobe is asserted for it.
- R12: Outputs depend on the current state only, so an opcode change within a cycle leaves that cycle's outputs unchanged. Any output not named for a cycle above is 0, and `mem_rd` and `mem_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, enters fetch |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write if the ALU reports equality |
| ir_we | output | 1 | Instruction register load |
| rf_we | output | 1 | Register file write |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| rf_dst_sel | output | 1 | Destination: 0 bits 20:16, 1 bits 15:11 |
| rf_wsrc_mem | output | 1 | Write data: 0 ALUOut, 1 MDR |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B input: 00 B, 01 four, 10 offset, 11 offset shifted by 2 |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALUOut, 10 jump target |

## Verification
The assertions assume that `opcode` holds the current instruction's opcode from the decode cycle through the address cycle of a load or store. Those are the only cycles whose successor depends on it. The bench changes the opcode only during a fetch cycle, or within a final cycle whose successor is fixed, and then only to test R12. Reset is applied shortly after a rising edge and released the same way, so that no assertion samples a partly reset state. The opcode stream mixes every supported class with two unused codes in a pseudo-random order.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;
  localparam int OPC_W   = 6;
  localparam int SEL2_W  = 2;
  localparam logic [OPC_W-1:0] OPC_ALU   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [SEL2_W-1:0] BSEL_REG  = 2'b00;
  localparam logic [SEL2_W-1:0] BSEL_FOUR = 2'b01;
  localparam logic [SEL2_W-1:0] BSEL_OFS  = 2'b10;
  localparam logic [SEL2_W-1:0] BSEL_OFS4 = 2'b11;
  localparam logic [SEL2_W-1:0] AOP_ADD   = 2'b00;
  localparam logic [SEL2_W-1:0] AOP_SUB   = 2'b01;
  localparam logic [SEL2_W-1:0] AOP_FUNCT = 2'b10;
  localparam logic [SEL2_W-1:0] PSRC_ALU  = 2'b00;
  localparam logic [SEL2_W-1:0] PSRC_OUT  = 2'b01;
  localparam logic [SEL2_W-1:0] PSRC_JMP  = 2'b10;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_LDRD, ST_LDWB,
    ST_STWR, ST_REXE, ST_RWB, ST_BEQ, ST_JMP
  } mstate_e;
  localparam int NUM_ST = 10;
  localparam int ST_W   = $bits(mstate_e);

  typedef enum logic [2:0] {
    K_ALU, K_LOAD, K_STORE, K_BEQ, K_JUMP, K_NONE
  } iclass_e;

  typedef struct packed {
    logic              pc_we;
    logic              pc_we_cond;
    logic              ir_we;
    logic              rf_we;
    logic              mem_rd;
    logic              mem_wr;
    logic              addr_sel;
    logic              rf_dst_sel;
    logic              rf_wsrc_mem;
    logic              alu_a_sel;
    logic [SEL2_W-1:0] alu_b_sel;
    logic [SEL2_W-1:0] alu_op;
    logic [SEL2_W-1:0] pc_src;
  } ctl_t;
endpackage

// File: rtl/mcyc_opdec.sv
module mcyc_opdec
  import mcyc_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output iclass_e          cls
);
  always_comb begin
    case (opcode)
      OPC_ALU:   cls = K_ALU;
      OPC_LOAD:  cls = K_LOAD;
      OPC_STORE: cls = K_STORE;
      OPC_BEQ:   cls = K_BEQ;
      OPC_JUMP:  cls = K_JUMP;
      default:   cls = K_NONE;
    endcase
  end
endmodule

// File: rtl/mcyc_next.sv
module mcyc_next
  import mcyc_ctrl_pkg::*;
(
  input  mstate_e cur,
  input  iclass_e cls,
  output mstate_e nxt
);
  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          K_ALU:            nxt = ST_REXE;
          K_LOAD, K_STORE:  nxt = ST_ADDR;
          K_BEQ:            nxt = ST_BEQ;
          K_JUMP:           nxt = ST_JMP;
          default:          nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:   nxt = (cls == K_LOAD) ? ST_LDRD : ST_STWR;
      ST_LDRD:   nxt = ST_LDWB;
      ST_REXE:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcyc_state_reg.sv
module mcyc_state_reg
  import mcyc_ctrl_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
)(
  input  logic    clk,
  input  logic    rst_n,
  input  mstate_e nxt,
  output mstate_e cur
);
  if (ONE_HOT) begin : g_onehot
    localparam logic [NUM_ST-1:0] HOT_ONE = NUM_ST'(1);
    logic [NUM_ST-1:0] oh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oh_q <= HOT_ONE << ST_FETCH;
      else        oh_q <= HOT_ONE << nxt;
    end
    always_comb begin
      cur = ST_FETCH;
      for (int i = 0; i < NUM_ST; i++) begin
        if (oh_q[i]) cur = mstate_e'(ST_W'(i));
      end
    end
  end else begin : g_binary
    mstate_e bin_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bin_q <= ST_FETCH;
      else        bin_q <= nxt;
    end
    assign cur = bin_q;
  end
endmodule

// File: rtl/mcyc_outdec.sv
module mcyc_outdec
  import mcyc_ctrl_pkg::*;
(
  input  mstate_e cur,
  output ctl_t    ctl
);
  always_comb begin
    ctl = '0;
    case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_we     = 1'b1;
        ctl.pc_we     = 1'b1;
        ctl.alu_b_sel = BSEL_FOUR;
        ctl.alu_op    = AOP_ADD;
        ctl.pc_src    = PSRC_ALU;
      end
      ST_DECODE: begin
        ctl.alu_b_sel = BSEL_OFS4;
        ctl.alu_op    = AOP_ADD;
      end
      ST_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_OFS;
        ctl.alu_op    = AOP_ADD;
      end
      ST_LDRD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_we       = 1'b1;
        ctl.rf_wsrc_mem = 1'b1;
      end
      ST_STWR: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_REXE: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_REG;
        ctl.alu_op    = AOP_FUNCT;
      end
      ST_RWB: begin
        ctl.rf_we      = 1'b1;
        ctl.rf_dst_sel = 1'b1;
      end
      ST_BEQ: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_b_sel  = BSEL_REG;
        ctl.alu_op     = AOP_SUB;
        ctl.pc_we_cond = 1'b1;
        ctl.pc_src     = PSRC_OUT;
      end
      ST_JMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_src = PSRC_JMP;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_ctrl_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  output logic              pc_we,
  output logic              pc_we_cond,
  output logic              ir_we,
  output logic              rf_we,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              addr_sel,
  output logic              rf_dst_sel,
  output logic              rf_wsrc_mem,
  output logic              alu_a_sel,
  output logic [SEL2_W-1:0] alu_b_sel,
  output logic [SEL2_W-1:0] alu_op,
  output logic [SEL2_W-1:0] pc_src
);
  iclass_e cls;
  mstate_e cur_st;
  mstate_e nxt_st;
  ctl_t    ctl;

  mcyc_opdec u_opdec (.opcode(opcode), .cls(cls));
  mcyc_next  u_next  (.cur(cur_st), .cls(cls), .nxt(nxt_st));
  mcyc_state_reg #(.ONE_HOT(ONE_HOT)) u_sreg (
    .clk(clk), .rst_n(rst_n), .nxt(nxt_st), .cur(cur_st)
  );
  mcyc_outdec u_outdec (.cur(cur_st), .ctl(ctl));

  assign pc_we       = ctl.pc_we;
  assign pc_we_cond  = ctl.pc_we_cond;
  assign ir_we       = ctl.ir_we;
  assign rf_we       = ctl.rf_we;
  assign mem_rd      = ctl.mem_rd;
  assign mem_wr      = ctl.mem_wr;
  assign addr_sel    = ctl.addr_sel;
  assign rf_dst_sel  = ctl.rf_dst_sel;
  assign rf_wsrc_mem = ctl.rf_wsrc_mem;
  assign alu_a_sel   = ctl.alu_a_sel;
  assign alu_b_sel   = ctl.alu_b_sel;
  assign alu_op      = ctl.alu_op;
  assign pc_src      = ctl.pc_src;
endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk
  import mcyc_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OPC_W-1:0]  opcode,
  input logic              pc_we,
  input logic              pc_we_cond,
  input logic              ir_we,
  input logic              rf_we,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              addr_sel,
  input logic              rf_dst_sel,
  input logic              rf_wsrc_mem,
  input logic              alu_a_sel,
  input logic [SEL2_W-1:0] alu_b_sel,
  input logic [SEL2_W-1:0] alu_op,
  input logic [SEL2_W-1:0] pc_src
);
  logic in_decode;
  logic unknown_op;
  assign in_decode  = (alu_b_sel == 2'b11) && !ir_we;
  assign unknown_op = !(opcode inside {6'b000000, 6'b100011, 6'b101011,
                                       6'b000100, 6'b000010});

  a_r1_fetch_group: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |-> (pc_we && mem_rd && !addr_sel && !mem_wr));

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> in_decode);

  a_r3_decode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_decode |-> !(pc_we || pc_we_cond || rf_we || mem_rd || mem_wr));

  a_r11_unknown_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_decode && unknown_op) |=> ir_we);

  a_r6_read_then_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_sel) |=> (rf_we && rf_wsrc_mem && !rf_dst_sel));

  a_r4_writeback_ends: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> ir_we);

  a_r7_store_ends: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_we);

  a_r8_alu_result_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !rf_wsrc_mem) |-> rf_dst_sel);

  a_r9_branch_ends: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_cond |-> (alu_a_sel && alu_op == 2'b01 && pc_src == 2'b01) ##1 ir_we);

  a_r10_jump_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_src == 2'b10) |=> ir_we);

  a_r12_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && $onehot0({pc_we, pc_we_cond}));
endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (.*);

// File: tb/tb_mcyc_ctrl.sv
`timescale 1ns/1ps
module tb_mcyc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'b000000;
  logic       pc_we, pc_we_cond, ir_we, rf_we, mem_rd, mem_wr;
  logic       addr_sel, rf_dst_sel, rf_wsrc_mem, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mcyc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond), .ir_we(ir_we), .rf_we(rf_we),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel),
    .rf_dst_sel(rf_dst_sel), .rf_wsrc_mem(rf_wsrc_mem), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src)
  );

  function automatic logic [15:0] pack(bit pw, bit pc, bit ir, bit rf, bit rd,
      bit wr, bit ad, bit ds, bit ws, bit a, logic [1:0] b, logic [1:0] o,
      logic [1:0] s);
    return {pw, pc, ir, rf, rd, wr, ad, ds, ws, a, b, o, s};
  endfunction

  function automatic logic [15:0] observed();
    return {pc_we, pc_we_cond, ir_we, rf_we, mem_rd, mem_wr, addr_sel,
            rf_dst_sel, rf_wsrc_mem, alu_a_sel, alu_b_sel, alu_op, pc_src};
  endfunction

  // step names: 0 fetch, 1 decode, 2 address, 3 read, 4 load write,
  // 5 store, 6 alu exec, 7 alu write, 8 branch, 9 jump
  function automatic logic [15:0] expect_for(int step);
    case (step)
      0: return pack(1,0,1,0,1,0,0,0,0,0,2'b01,2'b00,2'b00);
      1: return pack(0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00);
      2: return pack(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00);
      3: return pack(0,0,0,0,1,0,1,0,0,0,2'b00,2'b00,2'b00);
      4: return pack(0,0,0,1,0,0,0,0,1,0,2'b00,2'b00,2'b00);
      5: return pack(0,0,0,0,0,1,1,0,0,0,2'b00,2'b00,2'b00);
      6: return pack(0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00);
      7: return pack(0,0,0,1,0,0,0,1,0,0,2'b00,2'b00,2'b00);
      8: return pack(0,1,0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01);
      default: return pack(1,0,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10);
    endcase
  endfunction

  function automatic string tag_for(int step, bit unknown);
    case (step)
      0: return "R2";
      1: return unknown ? "R11" : "R3";
      2: return "R5";
      3, 4: return "R6";
      5: return "R7";
      6, 7: return "R8";
      8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] exp);
    logic [15:0] act;
    act = observed();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_instr(logic [5:0] op, int abort_at, bit late_change);
    int seq[$];
    bit unknown;
    unknown = 0;
    case (op)
      6'b000000: seq = '{0, 1, 6, 7};
      6'b100011: seq = '{0, 1, 2, 3, 4};
      6'b101011: seq = '{0, 1, 2, 5};
      6'b000100: seq = '{0, 1, 8};
      6'b000010: seq = '{0, 1, 9};
      default: begin seq = '{0, 1}; unknown = 1; end
    endcase
    foreach (seq[i]) begin
      @(negedge clk);
      check(tag_for(seq[i], unknown), expect_for(seq[i]));
      if (i == 0) opcode = op;
      if (i == abort_at) return;
      if (late_change && i == seq.size() - 1) begin
        opcode = ~op;
        #2;
        check("R12", expect_for(seq[i]));
      end
    end
    @(posedge clk);
    #2;
    check(unknown ? "R11" : "R4", expect_for(0));
  endtask

  task automatic apply_reset();
    @(posedge clk);
    #2 rst_n = 1'b0;
    #3 check("R1", expect_for(0));
    @(negedge clk);
    check("R1", expect_for(0));
    @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    #((200000 - 10) * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [5:0] pool [7];
    logic [15:0] lfsr;
    pool = '{6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010,
             6'b111111, 6'b000001};
    #5 check("R1", expect_for(0));
    @(posedge clk);
    #2 rst_n = 1'b1;

    // one of each class in fixed order, opcode in fetch is stale (R2)
    run_instr(6'b100011, -1, 0);
    run_instr(6'b101011, -1, 0);
    run_instr(6'b000000, -1, 0);
    run_instr(6'b000100, -1, 0);
    run_instr(6'b000010, -1, 0);
    run_instr(6'b110011, -1, 0);
    // opcode changed inside final cycles must not disturb them (R12)
    run_instr(6'b000000, -1, 1);
    run_instr(6'b100011, -1, 1);
    run_instr(6'b000010, -1, 1);
    // reset in the middle of a load (R1)
    run_instr(6'b100011, 3, 0);
    apply_reset();
    run_instr(6'b101011, -1, 0);
    // reset in decode of a branch
    run_instr(6'b000100, 1, 0);
    apply_reset();
    // pseudo-random mix
    lfsr = 16'hACE1;
    for (int n = 0; n < 80; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_instr(pool[lfsr % 7], -1, 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule